// File: doc/BRIEF.md
# Test-Monitor Event and Interrupt Register Bank

This block sits beside a test-pattern monitor and gathers what it reports. Three live condition levels (loss of frame alignment, loss of pattern sync, and an all-ones alarm) pass through a settling synchronizer. Any change of a settled level, up or down, sets a sticky delta bit. Three one-cycle event strobes (single bit error, framing error, CRC error) set sticky event bits. The CRC event is accepted only while the monitor runs in a CRC-carrying mode, meaning a DS1 extended superframe or an E1 multiframe.

All six sticky bits share one mask register, and together they drive one registered interrupt line. Software reaches the bank through a small byte-wide register port. A single control bit picks how the sticky bits are cleared. In one mode, reading the event register clears them. In the other mode, software clears a bit by writing a one to its position.

Top module: `tmon_irq_bank`

## Requirements
- R1: After reset every register reads 0x00 and `irq_o` is low. All mask bits are 0, so every source is unmasked.
- R2: Address 0x00 returns the settled live levels in bit 0 (frame loss), bit 1 (sync loss) and bit 2 (all-ones alarm). Bit 2 is 1 while all-ones data is reported and 0 otherwise. None of these bits is latched.
- R3: Event-register bits 0, 1 and 2 are deltas of status bits 0, 1 and 2. Each delta sets on any change of its settled level, whether the level rises or falls. A level change shows in the status register no earlier than two clocks after it appears at the input.
- R4: A strobe on `evt_bit_err_i`, `evt_frm_err_i` or `evt_crc_err_i` sets event bit 3, 4 or 5 respectively.
- R5: When `crc_mode_en_i` is 0, a CRC strobe leaves event bit 5 at 0.
- R6: While control bit 0 at address 0x03 is 1, a read of address 0x01 returns the event bits as they were before the read and then clears all of them. In this mode a write to 0x01 has no effect.
- R7: While control bit 0 is 0, writing a 1 to a bit of address 0x01 clears that bit. Writing a 0 leaves the bit unchanged, and reads do not clear anything.
- R8: If an event or delta sets in the same cycle as a clear, the bit stays set.
- R9: `irq_o` is high one clock after any event bit is set while its mask bit is 0. Mask bit n at address 0x02 masks event bit n. A set mask bit keeps its source from raising `irq_o`.
- R10: Read data appears on the clock after the read strobe and holds until the next read. Address 0x02 reads back bits 5:0 as written, and 0x03 reads back bit 0 as written. Unused bits and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_oof_i | input | 1 | Live frame-loss level (asynchronous) |
| stat_oos_i | input | 1 | Live pattern-sync-loss level (asynchronous) |
| stat_ais_i | input | 1 | Live all-ones alarm level (asynchronous) |
| evt_bit_err_i | input | 1 | Single bit error strobe |
| evt_frm_err_i | input | 1 | Framing error strobe |
| evt_crc_err_i | input | 1 | CRC error strobe |
| crc_mode_en_i | input | 1 | High while a CRC-carrying framing mode is selected |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, valid the clock after a read |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that event strobes and register strobes are synchronous to `clk`. They also assume a read and a write are never issued in the same cycle, and that nothing is driven while the internal reset is still settling. The bench drives every strobe and level on the falling edge and issues register accesses one at a time. It waits several clocks after releasing reset before its first access. It holds each status level long enough for the synchronizer and edge detector to settle before reading back.

// File: rtl/tmon_irq_pkg.sv
package tmon_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int NUM_STAT = 3;
  localparam int NUM_EVT  = 3;
  localparam int NUM_SRC  = NUM_STAT + NUM_EVT;

  localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_EVT  = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 8'h02;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h03;

  localparam int IDX_OOF = 0;
  localparam int IDX_OOS = 1;
  localparam int IDX_AIS = 2;
  localparam int IDX_BIT = 3;
  localparam int IDX_FRM = 4;
  localparam int IDX_CRC = 5;
endpackage

// File: rtl/tmon_sync.sv
module tmon_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] chg_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];
  logic [WIDTH-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = async_i;
      end else begin : g_rest
        always_comb stage_d[s] = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign lvl_o = stage_q[STAGES-1];
  assign chg_o = stage_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/tmon_evt_latch.sv
module tmon_evt_latch #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] evt_o
);
  logic [WIDTH-1:0] evt_q;
  logic [WIDTH-1:0] evt_d;
  logic             evt_en;

  always_comb begin
    evt_en = |set_i || |clr_i;
    evt_d  = (evt_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= '0;
    else if (evt_en) evt_q <= evt_d;
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/tmon_regif.sv
module tmon_regif
  import tmon_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_STAT-1:0] stat_i,
  input  logic [NUM_SRC-1:0]  evt_i,
  output logic [NUM_SRC-1:0]  mask_o,
  output logic                cor_o,
  output logic [NUM_SRC-1:0]  clr_o,
  output logic [DATA_W-1:0]   rdata_o
);
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic               cor_q, cor_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               mask_en, cor_en;

  always_comb begin
    mask_en = wr_i && (addr_i == ADDR_MASK);
    cor_en  = wr_i && (addr_i == ADDR_CTRL);
    mask_d  = wdata_i[NUM_SRC-1:0];
    cor_d   = wdata_i[0];

    rdata_d = '0;
    case (addr_i)
      ADDR_STAT: rdata_d[NUM_STAT-1:0] = stat_i;
      ADDR_EVT:  rdata_d[NUM_SRC-1:0]  = evt_i;
      ADDR_MASK: rdata_d[NUM_SRC-1:0]  = mask_q;
      ADDR_CTRL: rdata_d[0]            = cor_q;
      default:   rdata_d               = '0;
    endcase

    clr_o = '0;
    if (cor_q) begin
      if (rd_i && addr_i == ADDR_EVT) clr_o = '1;
    end else begin
      if (wr_i && addr_i == ADDR_EVT) clr_o = wdata_i[NUM_SRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cor_q <= 1'b0;
    else if (cor_en) cor_q <= cor_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign mask_o  = mask_q;
  assign cor_o   = cor_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/tmon_irq_bank.sv
module tmon_irq_bank
  import tmon_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_oof_i,
  input  logic              stat_oos_i,
  input  logic              stat_ais_i,
  input  logic              evt_bit_err_i,
  input  logic              evt_frm_err_i,
  input  logic              evt_crc_err_i,
  input  logic              crc_mode_en_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_STAT-1:0] stat_raw, stat_lvl, stat_chg;
  logic [NUM_EVT-1:0]  evt_raw;
  logic [NUM_SRC-1:0]  set_vec, clr_vec, evt_q, mask_q;
  logic                cor_q;
  logic                irq_q, irq_d;

  assign stat_raw = {stat_ais_i, stat_oos_i, stat_oof_i};
  assign evt_raw  = {evt_crc_err_i & crc_mode_en_i, evt_frm_err_i, evt_bit_err_i};
  assign set_vec  = {evt_raw, stat_chg};

  tmon_sync #(.WIDTH(NUM_STAT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (stat_raw),
    .lvl_o   (stat_lvl),
    .chg_o   (stat_chg)
  );

  tmon_evt_latch #(.WIDTH(NUM_SRC)) u_latch (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .evt_o (evt_q)
  );

  tmon_regif u_regif (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_i    (reg_rd_i),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .stat_i  (stat_lvl),
    .evt_i   (evt_q),
    .mask_o  (mask_q),
    .cor_o   (cor_q),
    .clr_o   (clr_vec),
    .rdata_o (reg_rdata_o)
  );

  always_comb irq_d = |(evt_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tmon_irq_chk.sv
module tmon_irq_chk
  import tmon_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              evt_bit_err_i,
  input logic              evt_crc_err_i,
  input logic              crc_mode_en_i,
  input logic [NUM_SRC-1:0] evt_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic              cor_q,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o
);
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bit_err_i |=> evt_q[IDX_BIT]); // R8

  AST_CRC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q[IDX_CRC]) |-> $past(evt_crc_err_i && crc_mode_en_i)); // R5

  AST_W1C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cor_q && !(reg_wr_i && reg_addr_i == ADDR_EVT)) |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |=> !irq_o); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_i |=> $stable(reg_rdata_o)); // R10
endmodule

bind tmon_irq_bank tmon_irq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .reg_rd_i      (reg_rd_i),
  .reg_wr_i      (reg_wr_i),
  .reg_addr_i    (reg_addr_i),
  .evt_bit_err_i (evt_bit_err_i),
  .evt_crc_err_i (evt_crc_err_i),
  .crc_mode_en_i (crc_mode_en_i),
  .evt_q         (evt_q),
  .mask_q        (mask_q),
  .cor_q         (cor_q),
  .reg_rdata_o   (reg_rdata_o),
  .irq_o         (irq_o)
);

// File: tb/test_tmon_irq_bank.sv
module test_tmon_irq_bank;
  logic       clk, rst_n;
  logic       stat_oof_i, stat_oos_i, stat_ais_i;
  logic       evt_bit_err_i, evt_frm_err_i, evt_crc_err_i, crc_mode_en_i;
  logic       reg_rd_i, reg_wr_i;
  logic [7:0] reg_addr_i, reg_wdata_i, reg_rdata_o;
  logic       irq_o;

  int n_run, n_fail;
  bit done;

  tmon_irq_bank i_tmon_irq_bank (
    .clk(clk), .rst_n(rst_n),
    .stat_oof_i(stat_oof_i), .stat_oos_i(stat_oos_i), .stat_ais_i(stat_ais_i),
    .evt_bit_err_i(evt_bit_err_i), .evt_frm_err_i(evt_frm_err_i),
    .evt_crc_err_i(evt_crc_err_i), .crc_mode_en_i(crc_mode_en_i),
    .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd_i = 1'b1; reg_addr_i = a;
    @(negedge clk); reg_rd_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk); reg_wr_i = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    evt_bit_err_i = (idx == 3); evt_frm_err_i = (idx == 4); evt_crc_err_i = (idx == 5);
    @(negedge clk);
    evt_bit_err_i = 0; evt_frm_err_i = 0; evt_crc_err_i = 0;
  endtask

  task automatic set_stat(input int idx, input logic v);
    @(negedge clk);
    case (idx)
      0: stat_oof_i = v;
      1: stat_oos_i = v;
      default: stat_ais_i = v;
    endcase
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    n_run = 0; n_fail = 0; done = 0;
    rst_n = 0;
    stat_oof_i = 0; stat_oos_i = 0; stat_ais_i = 0;
    evt_bit_err_i = 0; evt_frm_err_i = 0; evt_crc_err_i = 0; crc_mode_en_i = 1;
    reg_rd_i = 0; reg_wr_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state of every register and the interrupt
    for (int a = 0; a < 4; a++) begin
      rd(8'(a), d); check(d, 8'h00, "R1 reset reg");
    end
    check({7'd0, irq_o}, 8'h00, "R1 irq low");

    // R2 R3: each live level, rising then falling
    for (int b = 0; b < 3; b++) begin
      set_stat(b, 1'b1);
      rd(8'h00, d); check(d, 8'(1 << b), "R2 status high");
      rd(8'h01, d); check(d, 8'(1 << b), "R3 rising delta");
      check({7'd0, irq_o}, 8'h01, "R9 irq on delta");
      wr(8'h01, 8'(1 << b));
      rd(8'h01, d); check(d, 8'h00, "R7 delta cleared");
      set_stat(b, 1'b0);
      rd(8'h00, d); check(d, 8'h00, "R2 status low");
      rd(8'h01, d); check(d, 8'(1 << b), "R3 falling delta");
      wr(8'h01, 8'(1 << b));
    end

    // R4 R9: event strobes with mask off and on
    for (int b = 3; b < 6; b++) begin
      for (int m = 0; m < 2; m++) begin
        wr(8'h02, m ? 8'(1 << b) : 8'h00);
        pulse(b);
        @(negedge clk);
        check({7'd0, irq_o}, m ? 8'h00 : 8'h01, "R9 irq vs mask");
        rd(8'h01, d); check(d, 8'(1 << b), "R4 event latched");
        rd(8'h01, d); check(d, 8'(1 << b), "R7 read keeps bit");
        wr(8'h01, 8'(1 << b));
        @(negedge clk);
        check({7'd0, irq_o}, 8'h00, "R9 irq drops after clear");
        rd(8'h01, d); check(d, 8'h00, "R7 cleared");
      end
    end
    wr(8'h02, 8'h00);

    // R5: CRC strobe ignored outside CRC mode
    crc_mode_en_i = 0;
    pulse(5);
    @(negedge clk);
    check({7'd0, irq_o}, 8'h00, "R5 no irq");
    rd(8'h01, d); check(d, 8'h00, "R5 crc gated");
    crc_mode_en_i = 1;

    // R7: partial write-one clear, zero bits untouched
    pulse(3); pulse(4);
    wr(8'h01, 8'h08);
    rd(8'h01, d); check(d, 8'h10, "R7 partial clear");
    wr(8'h01, 8'h00);
    rd(8'h01, d); check(d, 8'h10, "R7 zero write no effect");
    wr(8'h01, 8'h10);

    // R8: set beats a write-one clear
    @(negedge clk); reg_wr_i = 1; reg_addr_i = 8'h01; reg_wdata_i = 8'h08; evt_bit_err_i = 1;
    @(negedge clk); reg_wr_i = 0; evt_bit_err_i = 0;
    rd(8'h01, d); check(d, 8'h08, "R8 set wins w1c");
    wr(8'h01, 8'h08);

    // R6: clear-on-read mode
    wr(8'h03, 8'h01);
    rd(8'h03, d); check(d, 8'h01, "R10 ctrl readback");
    pulse(4);
    wr(8'h01, 8'hFF);
    rd(8'h01, d); check(d, 8'h10, "R6 write ignored, read old value");
    rd(8'h01, d); check(d, 8'h00, "R6 cleared by read");

    // R8: set beats a read clear
    @(negedge clk); reg_rd_i = 1; reg_addr_i = 8'h01; evt_bit_err_i = 1;
    @(negedge clk); reg_rd_i = 0; evt_bit_err_i = 0;
    check(reg_rdata_o, 8'h00, "R8 read before set");
    rd(8'h01, d); check(d, 8'h08, "R8 set wins read");
    wr(8'h03, 8'h00);

    // R10: mask readback, unused address
    wr(8'h02, 8'hEA);
    rd(8'h02, d); check(d, 8'h2A, "R10 mask readback");
    rd(8'h07, d); check(d, 8'h00, "R10 unmapped");
    @(negedge clk);
    check(reg_rdata_o, 8'h00, "R10 hold");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule